// File: doc/BRIEF.md
# Single-Memory Bit-Reversal Reorder Buffer

This block takes a continuous stream of transform frames whose samples arrive in bit-reversed index order and hands them on in natural index order. It uses one memory of exactly N entries, with no second bank. Each accepted sample reads the entry at the current address and then overwrites that entry with the incoming value in the same cycle. The address comes from a sample counter. On alternate frames the counter is used either straight or with its log2(N) bits mirrored. Frame k is therefore read out in natural order while frame k+1 fills the locations that frame k frees.

The stream carries a valid qualifier and a start-of-frame marker. The first marked sample after reset aligns the counter, and frames are then expected back to back, counted in accepted samples. Idle cycles, with valid low, are allowed anywhere. The block holds back the whole first frame, so it adds a latency of one frame plus one clock.

Top module: `brev_reorder`

## Requirements
- R1: While reset (synchronous, active low) is applied and in the first cycle after it, `out_valid` and `out_sof` are 0 and `out_data` is 0.
- R2: Valid samples that arrive after reset and before the first sample with `in_sof` = 1 are dropped. They are not stored and they do not advance the sample position.
- R3: No output sample is produced for the first frame after reset or lock. `out_valid` stays 0 for those N accepted samples.
- R4: From the second frame on, every accepted input sample produces exactly one output sample in the next cycle. `out_valid` is `in_valid` delayed by one clock.
- R5: Output position j of frame f (f ≥ 1) equals the input sample that was at position rev(j) of frame f-1. rev(j) mirrors the log2(N) index bits, so bit b goes to bit log2(N)-1-b. This holds for every consecutive frame pair, while the internal addressing swaps between straight and mirrored on each frame.
- R6: `out_sof` is 1 exactly with output position 0 of each frame and is never 1 without `out_valid`.
- R7: A cycle with `in_valid` = 0 produces no output, and the sample position and addressing mode stay where they were.
- R8: After alignment, `in_sof` on a sample other than a frame's first has no effect on positions or data.
- R9: A reset applied in mid-stream returns the block to the state it has after R1, R2 and R3 (unaligned, priming).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_sof | input | 1 | Marks the first sample of an input frame |
| in_data | input | DATA_W | Input sample, frame in bit-reversed order |
| out_valid | output | 1 | Output sample qualifier |
| out_sof | output | 1 | Marks output position 0 |
| out_data | output | DATA_W | Output sample, frame in natural order |

## Verification
The bench builds the block with N = 16 and DATA_W = 16. With these values a 4-bit mirrored index gives non-trivial permutations: for example 1↔8 and 3↔12, while 6 and 9 map to themselves. It also runs six consecutive frames, so both the straight and the mirrored addressing phases occur three times each. Each sample value encodes its frame number and its natural index, which makes a misplaced, stale or duplicated entry visible in the value itself. Idle gaps of several spacings, stray start markers, samples sent before alignment and a reset in the middle of a frame then exercise the alignment and stall paths.

// File: rtl/brev_pkg.sv
// Package: types shared by the reorder buffer modules.
// Assumes nothing beyond a single clock domain.
package brev_pkg;

    // Addressing mode for the current frame: counter used straight or mirrored.
    typedef enum logic {
        ADDR_STRAIGHT = 1'b0,
        ADDR_MIRROR   = 1'b1
    } addr_mode_t;

endpackage

// File: rtl/brev_addr_gen.sv
// Module: brev_addr_gen
// Aligns to the first marked sample, counts accepted samples per frame and
// produces the memory address. The counter is used straight or with its
// bits mirrored, and the mode swaps on every frame boundary. It also tells
// the top when one full frame has been stored (primed).
// Assumes N is a power of two, at least 2, and frames are back to back.
module brev_addr_gen
    import brev_pkg::*;
#(
    parameter int N     = 16,
    parameter int LOG2N = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic             take,
    output logic             first_pos,
    output logic             primed,
    output logic [LOG2N-1:0] addr
);

    localparam logic [LOG2N-1:0] LAST_POS = LOG2N'(N - 1);

    logic             locked;
    logic [LOG2N-1:0] count;
    logic [LOG2N-1:0] count_mirror;
    addr_mode_t       mode;
    logic             frame_end;

    // Accept a sample once aligned, or when it carries the first start marker.
    assign take      = in_valid && (locked || in_sof);
    assign frame_end = take && (count == LAST_POS);
    assign first_pos = (count == '0);

    // Mirror the counter bits: bit b drives bit LOG2N-1-b.
    for (genvar b = 0; b < LOG2N; b++) begin : g_mirror
        assign count_mirror[b] = count[LOG2N-1-b];
    end

    // Select the address form for the current frame.
    assign addr = (mode == ADDR_MIRROR) ? count_mirror : count;

    // Alignment flag: set by the first marked sample, kept until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  locked <= 1'b0;
        else if (in_valid && in_sof) locked <= 1'b1;
    end

    // Sample position within the frame, wrapping after N accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)         count <= '0;
        else if (frame_end) count <= '0;
        else if (take)      count <= count + 1'b1;
    end

    // Addressing mode swaps on every completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode <= ADDR_STRAIGHT;
        else if (frame_end) mode <= (mode == ADDR_STRAIGHT) ? ADDR_MIRROR : ADDR_STRAIGHT;
    end

    // Primed once the first full frame sits in memory.
    always_ff @(posedge clk) begin
        if (!rst_n)         primed <= 1'b0;
        else if (frame_end) primed <= 1'b1;
    end

    // R5: every frame boundary swaps the addressing mode.
    assert_mode_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (mode != $past(mode)));

    // R7: an idle cycle leaves position and mode untouched.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(count) && $stable(mode)));

    // R2: before alignment nothing advances.
    assert_unlocked_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (count == '0 && !primed));

endmodule

// File: rtl/brev_store.sv
// Module: brev_store
// N-entry sample memory with read-before-write on one port. On a write
// cycle the old entry is captured into the read register and the new
// sample replaces it. Only the read register is reset; the array is not.
module brev_store #(
    parameter int N      = 16,
    parameter int DATA_W = 16,
    parameter int LOG2N  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LOG2N-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [N];

    // Capture the entry's old value before it is overwritten.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (we) rdata <= mem[addr];
    end

    // Overwrite the entry with the incoming sample.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

endmodule

// File: rtl/brev_reorder.sv
// Module: brev_reorder (top)
// Turns a stream of bit-reversed frames into natural order using one
// N-entry memory. Output lags the input by one frame plus one clock.
// Assumes N is a power of two and frames are contiguous in accepted samples.
module brev_reorder #(
    parameter int N      = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sof,
    output logic [DATA_W-1:0] out_data
);

    localparam int LOG2N = $clog2(N);

    logic             take;
    logic             first_pos;
    logic             primed;
    logic [LOG2N-1:0] addr;

    brev_addr_gen #(.N(N), .LOG2N(LOG2N)) i_addr_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .take      (take),
        .first_pos (first_pos),
        .primed    (primed),
        .addr      (addr)
    );

    brev_store #(.N(N), .DATA_W(DATA_W), .LOG2N(LOG2N)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (take),
        .addr  (addr),
        .wdata (in_data),
        .rdata (out_data)
    );

    // Output qualifiers: one per accepted sample once primed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
        end else begin
            out_valid <= take && primed;
            out_sof   <= take && primed && first_pos;
        end
    end

    // R4: an output sample always follows an input sample by one clock.
    assert_out_follows_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R3: nothing comes out before a full frame has been stored.
    assert_no_out_priming_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(primed));

    // R6: the frame marker only appears on a valid output.
    assert_sof_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

endmodule

// File: tb/test_brev_reorder.sv
`timescale 1ns/1ps
module test_brev_reorder;

    localparam int N      = 16;
    localparam int DATA_W = 16;
    localparam int LOG2N  = $clog2(N);
    localparam int NV     = 6;
    // Vector table: idle gap spacing (0 = none) and stray start-marker position (0 = none).
    localparam int GAP   [NV] = '{0, 3, 0, 2, 0, 5};
    localparam int STRAY [NV] = '{0, 0, 5, 0, 9, 13};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_sof;
    logic [DATA_W-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    brev_reorder #(.N(N), .DATA_W(DATA_W)) i_brev_reorder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
    );

    function automatic int mirror(input int v);
        int r = 0;
        for (int b = 0; b < LOG2N; b++) if (v[b]) r |= (1 << (LOG2N - 1 - b));
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle, then sample the registered outputs just after the edge.
    task automatic cycle(input bit v, input bit s, input int d);
        @(negedge clk);
        in_valid = v; in_sof = s; in_data = DATA_W'(d);
        @(posedge clk);
        #1;
    endtask

    // Send frame f (bit-reversed order); check output of frame f-1 when expect_out.
    task automatic send_frame(input int f, input int gap, input int stray, input bit expect_out);
        for (int p = 0; p < N; p++) begin
            cycle(1'b1, (p == 0) || (stray != 0 && p == stray), f * 256 + mirror(p));
            if (expect_out) begin
                check(out_valid === 1'b1, "R4", out_valid, 1);
                check(out_data === DATA_W'((f - 1) * 256 + p), "R5 R8", out_data, (f - 1) * 256 + p);
                check(out_sof === (p == 0), "R6", out_sof, p == 0);
            end else begin
                check(out_valid === 1'b0, "R3", out_valid, 0);
            end
            if (gap != 0 && (p % gap) == gap - 1) begin
                cycle(1'b0, 1'b0, 16'hdead);
                check(out_valid === 1'b0 && out_sof === 1'b0, "R7", out_valid, 0);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) cycle(1'b0, 1'b0, 0);
        check(out_valid === 1'b0 && out_sof === 1'b0 && out_data === '0, "R1", out_data, 0);
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, 0);
        check(out_valid === 1'b0 && out_data === '0, "R1", out_valid, 0);
        // R2: unaligned samples are dropped
        for (int k = 0; k < 3; k++) begin
            cycle(1'b1, 1'b0, 16'h7700 + k);
            check(out_valid === 1'b0, "R2", out_valid, 0);
        end
        // Table walk: six consecutive frames, first one primes (R3)
        for (int f = 0; f < NV; f++) send_frame(f, GAP[f], STRAY[f], f != 0);
        // R9: reset in mid-frame
        for (int p = 0; p < N / 2; p++) cycle(1'b1, p == 0, 16'h4400 + p);
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1;
        check(out_valid === 1'b0 && out_data === '0, "R9", out_data, 0);
        rst_n = 1'b1;
        send_frame(10, 0, 0, 1'b0);
        send_frame(11, 4, 0, 1'b1);
        cycle(1'b0, 1'b0, 0);
        check(out_valid === 1'b0, "R7", out_valid, 0);
        finish_run();
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule